// File: doc/BRIEF.md
# Colour Lookup Table Host Access Sequencer

This block gives a host byte-wide access to a 256-entry colour lookup table whose entries are three bytes wide. The host works through a single operation code per cycle. It can set a read pointer, set a write pointer, push a data byte or pull a data byte. Writes are staged, and an entry changes only when all three components are present, so a display that scans the table never shows a half-updated colour. Reads step through the components of the entry under the read pointer. Both pointers advance by one after every third component.

The table sits inside the block as a synchronous RAM with one write port and two read ports. One read port serves the host data pulls. The other is a free-running pixel lookup port that the host sequencing never stalls. The block reports an access-state code and the current write pointer.

Top module: `clut_host_seq`

## Requirements
- R1: During and after reset, with no operation yet, `wr_ptr` is 0, `acc_state` is 0 and `rd_valid` is 0. The shared component counter is 0, so the first data operation uses component 0.
- R2: Operation code 1 (set read pointer) loads `host_wdata` into the read pointer, clears the component counter and sets `acc_state` to 3 from the next cycle.
- R3: Operation code 2 (set write pointer) loads `host_wdata` into the write pointer, clears the component counter and sets `acc_state` to 0. `wr_ptr` shows the new value from the next cycle.
- R4: Operation code 3 (data write) stages `host_wdata` as component number (counter), then advances the counter. On the third component the entry at the write pointer is replaced by {component0, component1, component2}, with component 0 in bits [23:16]. The counter then returns to 0 and the write pointer increments.
- R5: A partially written triplet leaves the table entry unchanged until its third component arrives.
- R6: Operation code 4 (data read) raises `rd_valid` in the next cycle. In that cycle `rd_data` holds component (counter) of the entry at the read pointer. The counter advances, and after the third component the read pointer increments.
- R7: Both pointers are 8 bits wide and wrap from 255 to 0.
- R8: Reads and writes share one component counter. A read that falls between data writes consumes a component slot, and the slot it skips keeps the byte last staged there.
- R9: `pix_rgb` holds the entry at `pix_addr` one cycle after it is presented, whatever the host does. When a commit to that same entry happens in that cycle, `pix_rgb` returns the old value.
- R10: Operation codes 0, 5, 6 and 7 change neither pointer, the counter, `acc_state` nor any entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_op | input | 3 | Host operation code for this cycle |
| host_wdata | input | 8 | Pointer value or data byte for the operation |
| rd_data | output | 8 | Component returned by the last data read |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| wr_ptr | output | 8 | Current write pointer |
| acc_state | output | 2 | Access state: 3 after a read-pointer load, 0 after a write-pointer load |
| pix_addr | input | 8 | Pixel-side lookup address |
| pix_rgb | output | 24 | Entry at the pixel address, one cycle later |

## Verification
The bench looks for triplets that commit early: a design doing so would show a mixed old and new colour on the pixel port while only two bytes had arrived. It mixes reads and writes inside one triplet. A design with separate read and write counters, or one that clears stale staged bytes, commits a different entry from the model. It runs both pointers across 255. A pointer that saturates, or that is wider than eight bits, leaves the write pointer and the read-back data wrong. It also aims the pixel port at the entry being committed. Write-first RAM behaviour would show the new colour one cycle early.

// File: rtl/clut_pkg.sv
// Shared types and constants for the lookup-table host access sequencer.
package clut_pkg;
    typedef enum logic [2:0] {
        OP_IDLE    = 3'd0,
        OP_SET_RD  = 3'd1,
        OP_SET_WR  = 3'd2,
        OP_DATA_WR = 3'd3,
        OP_DATA_RD = 3'd4
    } host_op_t;

    localparam logic [1:0] ACC_WRITE = 2'd0;
    localparam logic [1:0] ACC_READ  = 2'd3;
endpackage

// File: rtl/clut_seq_ctrl.sv
// Host sequencing: pointers, shared component counter, staging bytes and
// commit formation. Assumes NCOMP >= 2 and one host operation per cycle.
module clut_seq_ctrl
    import clut_pkg::*;
#(
    parameter int PTR_W  = 8,
    parameter int COMP_W = 8,
    parameter int NCOMP  = 3,
    localparam int SUB_W = $clog2(NCOMP),
    localparam int ENT_W = NCOMP * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        host_op,
    input  logic [COMP_W-1:0] host_wdata,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic [SUB_W-1:0]  sub_idx,
    output logic [1:0]        acc_state,
    output logic              commit_en,
    output logic [ENT_W-1:0]  commit_data,
    output logic              rd_fire
);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(NCOMP - 1);

    host_op_t                op_e;
    logic                    last_sub;
    logic [COMP_W-1:0]       stage_q [NCOMP-1];

    assign op_e      = host_op_t'(host_op);
    assign last_sub  = (sub_idx == SUB_LAST);
    assign commit_en = (op_e == OP_DATA_WR) && last_sub;
    assign rd_fire   = (op_e == OP_DATA_RD);

    // Pack staged components (component 0 most significant) plus the final byte.
    always_comb begin
        commit_data = '0;
        for (int k = 0; k < NCOMP - 1; k++) begin
            commit_data[(NCOMP-1-k)*COMP_W +: COMP_W] = stage_q[k];
        end
        commit_data[COMP_W-1:0] = host_wdata;
    end

    // Staging bytes: one register per component except the last.
    generate
        for (genvar g = 0; g < NCOMP - 1; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage_q[g] <= '0;
                else if (op_e == OP_DATA_WR && sub_idx == SUB_W'(g))
                    stage_q[g] <= host_wdata;
            end
        end
    endgenerate

    // Pointer, counter and state updates per operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            sub_idx   <= '0;
            acc_state <= ACC_WRITE;
        end else begin
            case (op_e)
                OP_SET_RD: begin
                    rd_ptr    <= PTR_W'(host_wdata);
                    sub_idx   <= '0;
                    acc_state <= ACC_READ;
                end
                OP_SET_WR: begin
                    wr_ptr    <= PTR_W'(host_wdata);
                    sub_idx   <= '0;
                    acc_state <= ACC_WRITE;
                end
                OP_DATA_WR: begin
                    if (last_sub) begin
                        sub_idx <= '0;
                        wr_ptr  <= wr_ptr + 1'b1;
                    end else begin
                        sub_idx <= sub_idx + 1'b1;
                    end
                end
                OP_DATA_RD: begin
                    if (last_sub) begin
                        sub_idx <= '0;
                        rd_ptr  <= rd_ptr + 1'b1;
                    end else begin
                        sub_idx <= sub_idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R2
    set_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_op == 3'd1) |=> (acc_state == ACC_READ && sub_idx == '0
                               && rd_ptr == PTR_W'($past(host_wdata))));
    // R3
    set_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_op == 3'd2) |=> (acc_state == ACC_WRITE && sub_idx == '0
                               && wr_ptr == PTR_W'($past(host_wdata))));
    // R4
    commit_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |=> (sub_idx == '0 && wr_ptr == PTR_W'($past(wr_ptr) + 1'b1)));
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_op == 3'd0 || host_op > 3'd4) |=>
            ($stable(wr_ptr) && $stable(rd_ptr) && $stable(sub_idx) && $stable(acc_state)));
    // R8
    sub_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_idx <= SUB_LAST));
endmodule

// File: rtl/clut_ram.sv
// Lookup-table storage: one synchronous write port and two registered read
// ports. A read at the address being written returns the old contents.
module clut_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 24,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ra_en,
    input  logic [ADDR_W-1:0] ra_addr,
    output logic [DATA_W-1:0] ra_q,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic [DATA_W-1:0] rb_q
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Array write port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Host read port, enabled per data read.
    always_ff @(posedge clk) begin
        if (!rst_n)     ra_q <= '0;
        else if (ra_en) ra_q <= mem[ra_addr];
    end

    // Pixel read port, free running.
    always_ff @(posedge clk) begin
        if (!rst_n) rb_q <= '0;
        else        rb_q <= mem[rb_addr];
    end
endmodule

// File: rtl/clut_host_seq.sv
// Top: lookup-table host access sequencer. Combines sequencing control,
// the 1W2R table and the component select for host reads. One host
// operation per cycle; read data appears the cycle after the request.
module clut_host_seq
    import clut_pkg::*;
#(
    parameter int PTR_W  = 8,
    parameter int COMP_W = 8,
    parameter int NCOMP  = 3,
    localparam int SUB_W = $clog2(NCOMP),
    localparam int ENT_W = NCOMP * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        host_op,
    input  logic [COMP_W-1:0] host_wdata,
    output logic [COMP_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic [1:0]        acc_state,
    input  logic [PTR_W-1:0]  pix_addr,
    output logic [ENT_W-1:0]  pix_rgb
);
    logic [PTR_W-1:0] rd_ptr;
    logic [SUB_W-1:0] sub_idx;
    logic             commit_en;
    logic [ENT_W-1:0] commit_data;
    logic             rd_fire;
    logic [ENT_W-1:0] host_q;
    logic [SUB_W-1:0] sel_q;

    clut_seq_ctrl #(.PTR_W(PTR_W), .COMP_W(COMP_W), .NCOMP(NCOMP)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_op    (host_op),
        .host_wdata (host_wdata),
        .wr_ptr     (wr_ptr),
        .rd_ptr     (rd_ptr),
        .sub_idx    (sub_idx),
        .acc_state  (acc_state),
        .commit_en  (commit_en),
        .commit_data(commit_data),
        .rd_fire    (rd_fire)
    );

    clut_ram #(.ADDR_W(PTR_W), .DATA_W(ENT_W)) u_ram (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (commit_en),
        .waddr  (wr_ptr),
        .wdata  (commit_data),
        .ra_en  (rd_fire),
        .ra_addr(rd_ptr),
        .ra_q   (host_q),
        .rb_addr(pix_addr),
        .rb_q   (pix_rgb)
    );

    // Remember which component a read asked for, and flag its result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_fire;
            if (rd_fire) sel_q <= sub_idx;
        end
    end

    // Pick the requested component from the registered entry.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NCOMP; k++) begin
            if (sel_q == SUB_W'(k)) rd_data = host_q[(NCOMP-1-k)*COMP_W +: COMP_W];
        end
    end

    // R6
    rd_valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_op == 3'd4) |=> rd_valid);
    // R6
    rd_valid_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_op != 3'd4) |=> !rd_valid);
endmodule

// File: tb/clut_host_seq_bench.sv
// Bench: behavioural reference model of the sequencer, compared every clock.
module clut_host_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host_op = 3'd0;
    logic [7:0]  host_wdata = 8'd0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [7:0]  wr_ptr;
    logic [1:0]  acc_state;
    logic [7:0]  pix_addr = 8'd0;
    logic [23:0] pix_rgb;

    clut_host_seq u_clut_host_seq (
        .clk(clk), .rst_n(rst_n), .host_op(host_op), .host_wdata(host_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .wr_ptr(wr_ptr),
        .acc_state(acc_state), .pix_addr(pix_addr), .pix_rgb(pix_rgb)
    );

    always #2 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_tag = "R1";

    int          m_rd = 0, m_wr = 0, m_sub = 0, m_state = 0;
    logic [7:0]  m_stage [3] = '{8'd0, 8'd0, 8'd0};
    logic [23:0] m_tab [256];
    bit          m_known [256];

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input int op, input int d, input int pa);
        logic [23:0] e_pix;
        bit          e_pix_k;
        bit          e_rv;
        int          e_rd;
        bit          e_rd_k;
        host_op    = 3'(op);
        host_wdata = 8'(d);
        pix_addr   = 8'(pa);
        e_pix   = m_tab[pa];
        e_pix_k = m_known[pa];
        e_rv    = (op == 4);
        e_rd    = 0;
        e_rd_k  = 1'b0;
        case (op)
            1: begin m_rd = d; m_sub = 0; m_state = 3; end
            2: begin m_wr = d; m_sub = 0; m_state = 0; end
            3: begin
                m_stage[m_sub] = 8'(d);
                m_sub++;
                if (m_sub == 3) begin
                    m_tab[m_wr]   = {m_stage[0], m_stage[1], m_stage[2]};
                    m_known[m_wr] = 1'b1;
                    m_sub = 0;
                    m_wr  = (m_wr + 1) % 256;
                end
            end
            4: begin
                e_rd   = int'((m_tab[m_rd] >> (8 * (2 - m_sub))) & 24'hFF);
                e_rd_k = m_known[m_rd];
                m_sub++;
                if (m_sub == 3) begin
                    m_sub = 0;
                    m_rd  = (m_rd + 1) % 256;
                end
            end
            default: ;
        endcase
        @(posedge clk);
        #1;
        chk(cur_tag, "wr_ptr", int'(wr_ptr), m_wr);
        chk(cur_tag, "acc_state", int'(acc_state), m_state);
        chk(cur_tag, "rd_valid", int'(rd_valid), int'(e_rv));
        if (e_rv && e_rd_k) chk(cur_tag, "rd_data", int'(rd_data), e_rd);
        if (e_pix_k) chk(cur_tag, "pix_rgb", int'(pix_rgb), int'(e_pix));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) m_known[i] = 1'b0;
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "wr_ptr", int'(wr_ptr), 0);
        chk("R1", "acc_state", int'(acc_state), 0);
        chk("R1", "rd_valid", int'(rd_valid), 0);
        rst_n = 1'b1;
        step(0, 0, 0);

        // R9: fill every entry, then sweep the pixel port
        cur_tag = "R9";
        step(2, 0, 0);
        for (int i = 0; i < 256; i++) begin
            step(3, i, i);
            step(3, (~i) & 8'hFF, i);
            step(3, i ^ 8'h5A, (i + 3) % 256);
        end
        for (int i = 0; i < 256; i++) step(0, 0, (i * 7) % 256);

        // R3: write pointer load
        cur_tag = "R3";
        step(3, 8'h11, 5);
        step(2, 10, 10);
        // R4: full triplets commit and advance
        cur_tag = "R4";
        step(3, 8'hA1, 10);
        step(3, 8'hB2, 10);
        step(3, 8'hC3, 10);
        step(0, 0, 10);
        step(3, 8'h01, 11);
        step(3, 8'h02, 11);
        step(3, 8'h03, 11);
        step(0, 0, 11);
        // R5: partial triplet leaves entry alone
        cur_tag = "R5";
        step(2, 11, 11);
        step(3, 8'hEE, 11);
        step(3, 8'hDD, 11);
        step(0, 0, 11);
        step(0, 0, 11);
        step(3, 8'hCC, 11);
        step(0, 0, 11);
        // R2: read pointer load
        cur_tag = "R2";
        step(4, 0, 0);
        step(1, 10, 0);
        // R6: reads step through components and entries
        cur_tag = "R6";
        for (int i = 0; i < 7; i++) step(4, 0, 0);
        step(0, 0, 0);
        // R8: shared counter across reads and writes
        cur_tag = "R8";
        step(1, 10, 0);
        step(2, 20, 20);
        step(3, 8'h77, 20);
        step(4, 0, 20);
        step(3, 8'h99, 20);
        step(0, 0, 20);
        step(1, 20, 20);
        step(4, 0, 20);
        step(4, 0, 20);
        step(4, 0, 20);
        // R7: pointer wrap
        cur_tag = "R7";
        step(2, 255, 255);
        for (int i = 0; i < 6; i++) step(3, 8'h30 + i, (i < 3) ? 255 : 0);
        step(1, 255, 0);
        for (int i = 0; i < 6; i++) step(4, 0, 255);
        // R10: unused codes and idle have no effect
        cur_tag = "R10";
        step(1, 40, 40);
        step(4, 0, 40);
        step(0, 8'h12, 40);
        step(5, 8'h34, 40);
        step(6, 8'h56, 40);
        step(7, 8'h78, 40);
        step(4, 0, 40);
        step(4, 0, 40);
        // R9: pixel read of the entry being committed returns old data
        cur_tag = "R9";
        step(2, 60, 60);
        step(3, 8'hF0, 60);
        step(3, 8'hF1, 60);
        step(3, 8'hF2, 60);
        step(0, 0, 60);
        step(0, 0, 61);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule